// File: doc/BRIEF.md
# PS/2 Port Register Front End

This block is the processor-facing register interface of a PS/2 keyboard or mouse port. It sits on a simple synchronous register bus and decodes word-aligned offsets within a 4 KB window. The window holds a control word, a status word, a data port, a clock-divisor word and an interrupt-status word. A strip of read-only identification bytes sits at the top of the window. The serial line signalling and the attached peripheral are outside the block.

Received bytes come from a downstream device model through a byte-stream handshake. The model raises an availability flag and presents a byte, and the block answers with a one-cycle pop strobe when software reads the data port. A byte written to the data port goes out to the model as a byte with a one-cycle valid strobe. One interrupt output has two terms. The first is receive-pending gated by one control bit. The second is a forcing term from another control bit.

Read data and the bad-access flag are registered. They are valid in the cycle after the access.

Top module: `ps2c_top`

## Requirements
- R1: After reset, the control word, the clock-divisor word, the last-received byte and the pending flag are zero. As a result, irq, rdData, badAccess, devPop and txValid are all low.
- R2: The control word (offset 0x000) and the clock-divisor word (offset 0x00C) store all 32 bits written to them. A read returns the stored value on rdData in the cycle after the access.
- R3: A read of the status word (offset 0x004) returns bit 6 = 1 (transmit empty) and bit 4 = pending. Bit 2 is the XOR of all 8 bits of the last-received byte. Every other bit is 0.
- R4: A read of the data port (offset 0x008) while pending is 1 loads devByte into the last-received byte and returns it. devPop is then high for exactly the one cycle after the access. While pending is 0, the read returns the previous last-received byte and devPop stays low.
- R5: A write to the data port puts wrData[7:0] on txByte, with txValid high for the one cycle after the access.
- R6: irq equals (pending AND control bit 4) OR control bit 3. It follows a control write in the cycle after the write, and it follows the pending flag in the same cycle that the flag changes.
- R7: A read of the interrupt-status word (offset 0x010) returns bit 0 = pending and bit 1 = 1, with all other bits 0.
- R8: Reads at offsets 0xFE0 to 0xFFF return, in bits 7:0, the identification byte selected by (offset-0xFE0)>>2, with bits 31:8 zero. The bytes in order are 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1. These reads do not raise badAccess.
- R9: A read at any other offset returns 0 and raises badAccess for the one cycle after the access.
- R10: A write is ignored when its target is not the control word, the clock divisor or the data port, that is, the status word, the interrupt-status word, an unused offset or the identification strip. It changes no stored register and raises badAccess for the one cycle after the access.
- R11: The pending flag is devAvail registered once. A status read issued in the same cycle that devAvail rises still reports bit 4 = 0, and the next read reports 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Bus access select |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte offset in the 4 KB window |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid in the cycle after a read |
| badAccess | output | 1 | Access to an unmapped or non-writable offset, one cycle after it |
| devAvail | input | 1 | Device has a byte ready |
| devByte | input | 8 | Byte offered by the device |
| devPop | output | 1 | One-cycle pulse: the offered byte was taken |
| txByte | output | 8 | Byte sent to the device |
| txValid | output | 1 | One-cycle pulse qualifying txByte |
| irq | output | 1 | Interrupt output |

## Verification
The bench reads the data port twice, once with a byte pending and once without. A design that popped unconditionally would pulse devPop on the second read, and one that cleared the held byte would return zero. Parity is checked on a byte with an odd count of ones, before and after it is captured. A design that computed parity from devByte instead of the held byte would show bit 2 too early. The bench issues a status read in the same cycle that devAvail rises, which exposes a design that lets devAvail bypass the pending register. It also writes to the status word and the identification strip and then reads the real registers back. A decoder that let such writes through would corrupt the control word, and one that failed to treat the identification strip as read-only would be caught as well.

// File: rtl/ps2c_pkg.sv
package ps2c_pkg;
  localparam int ID_IDX_W = 3;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_CTRL = 3'd1,
    SEL_STAT = 3'd2,
    SEL_DATA = 3'd3,
    SEL_DIV  = 3'd4,
    SEL_ISR  = 3'd5,
    SEL_ID   = 3'd6
  } rdSel_e;

  typedef struct packed {
    logic                wrCtrl;
    logic                wrDiv;
    logic                wrTx;
    logic                popRx;
    rdSel_e              rdSel;
    logic [ID_IDX_W-1:0] idIdx;
  } ctlStrobes_t;
endpackage

// File: rtl/ps2c_ctl.sv
module ps2c_ctl
  import ps2c_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ID_BASE = 12'hFE0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic              pending,
  output ctlStrobes_t       strobes,
  output logic              badAccess
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] IDX_CTRL = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_STAT = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_DIV  = IDX_W'(3);
  localparam logic [IDX_W-1:0] IDX_ISR  = IDX_W'(4);

  logic [IDX_W-1:0] regIdx;
  logic             inIdStrip;
  logic [ADDR_W-1:0] idOffset;
  logic             badNow;

  assign regIdx    = addr[ADDR_W-1:2];
  assign inIdStrip = (addr >= ID_BASE);
  assign idOffset  = addr - ID_BASE;

  always_comb begin
    strobes        = '0;
    strobes.rdSel  = SEL_NONE;
    strobes.idIdx  = idOffset[ID_IDX_W+1:2];
    badNow         = 1'b0;
    if (cs && !we) begin
      if (inIdStrip) begin
        strobes.rdSel = SEL_ID;
      end else begin
        unique case (regIdx)
          IDX_CTRL: strobes.rdSel = SEL_CTRL;
          IDX_STAT: strobes.rdSel = SEL_STAT;
          IDX_DATA: begin
            strobes.rdSel = SEL_DATA;
            strobes.popRx = pending;
          end
          IDX_DIV:  strobes.rdSel = SEL_DIV;
          IDX_ISR:  strobes.rdSel = SEL_ISR;
          default:  badNow = 1'b1;
        endcase
      end
    end else if (cs && we) begin
      if (inIdStrip) begin
        badNow = 1'b1;
      end else begin
        unique case (regIdx)
          IDX_CTRL: strobes.wrCtrl = 1'b1;
          IDX_DATA: strobes.wrTx   = 1'b1;
          IDX_DIV:  strobes.wrDiv  = 1'b1;
          default:  badNow = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) badAccess <= 1'b0;
    else       badAccess <= badNow;
  end

  // identification reads are legal
  assert_id_not_bad_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cs && !we && inIdStrip) |=> !badAccess);

  // status and interrupt-status are not writable
  assert_ro_write_bad_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cs && we && !inIdStrip && (regIdx == IDX_STAT || regIdx == IDX_ISR)) |=> badAccess);
endmodule

// File: rtl/ps2c_dp.sv
module ps2c_dp
  import ps2c_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic              devAvail,
  input  logic [BYTE_W-1:0] devByte,
  output logic              pending,
  output logic [DATA_W-1:0] rdData,
  output logic              devPop,
  output logic [BYTE_W-1:0] txByte,
  output logic              txValid,
  output logic              irq
);
  localparam int BIT_TXEMPTY = 6;
  localparam int BIT_RXFULL  = 4;
  localparam int BIT_RXPAR   = 2;
  localparam int BIT_IRQ_RX  = 4;
  localparam int BIT_IRQ_FRC = 3;

  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] divReg;
  logic [BYTE_W-1:0] lastByte;
  logic [BYTE_W-1:0] nextLast;
  logic              lastParity;
  logic [DATA_W-1:0] readValue;

  function automatic logic [BYTE_W-1:0] idByte(input logic [ID_IDX_W-1:0] i);
    case (i)
      3'd0:    idByte = BYTE_W'(8'h50);
      3'd1:    idByte = BYTE_W'(8'h10);
      3'd2:    idByte = BYTE_W'(8'h04);
      3'd3:    idByte = BYTE_W'(8'h00);
      3'd4:    idByte = BYTE_W'(8'h0D);
      3'd5:    idByte = BYTE_W'(8'hF0);
      3'd6:    idByte = BYTE_W'(8'h05);
      default: idByte = BYTE_W'(8'hB1);
    endcase
  endfunction

  assign lastParity = ^lastByte;
  assign nextLast   = strobes.popRx ? devByte : lastByte;

  always_comb begin
    readValue = '0;
    unique case (strobes.rdSel)
      SEL_CTRL: readValue = ctrlReg;
      SEL_DIV:  readValue = divReg;
      SEL_DATA: readValue = DATA_W'(nextLast);
      SEL_STAT: begin
        readValue[BIT_TXEMPTY] = 1'b1;
        readValue[BIT_RXFULL]  = pending;
        readValue[BIT_RXPAR]   = lastParity;
      end
      SEL_ISR: begin
        readValue[0] = pending;
        readValue[1] = 1'b1;
      end
      SEL_ID:  readValue = DATA_W'(idByte(strobes.idIdx));
      default: readValue = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      divReg   <= '0;
      lastByte <= '0;
      pending  <= 1'b0;
      rdData   <= '0;
      devPop   <= 1'b0;
      txByte   <= '0;
      txValid  <= 1'b0;
    end else begin
      pending  <= devAvail;
      lastByte <= nextLast;
      rdData   <= readValue;
      devPop   <= strobes.popRx;
      txValid  <= strobes.wrTx;
      if (strobes.wrCtrl) ctrlReg <= wrData;
      if (strobes.wrDiv)  divReg  <= wrData;
      if (strobes.wrTx)   txByte  <= wrData[BYTE_W-1:0];
    end
  end

  assign irq = (pending && ctrlReg[BIT_IRQ_RX]) || ctrlReg[BIT_IRQ_FRC];

  // a pop only follows a cycle in which a byte was pending
  assert_pop_needs_pending_R4: assert property (@(posedge clk) disable iff (!rstN)
    devPop |-> $past(pending));

  // data port write reaches the device one cycle later
  assert_tx_follows_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrTx |=> (txValid && txByte == $past(wrData[BYTE_W-1:0])));

  // without a pop the held byte is stable
  assert_last_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.popRx |=> $stable(lastByte));
endmodule

// File: rtl/ps2c_top.sv
module ps2c_top
  import ps2c_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              badAccess,
  input  logic              devAvail,
  input  logic [BYTE_W-1:0] devByte,
  output logic              devPop,
  output logic [BYTE_W-1:0] txByte,
  output logic              txValid,
  output logic              irq
);
  ctlStrobes_t strobes;
  logic        pending;

  ps2c_ctl #(.ADDR_W(ADDR_W), .ID_BASE(ADDR_W'(12'hFE0))) u_ctl (
    .clk(clk), .rstN(rstN), .cs(cs), .we(we), .addr(addr),
    .pending(pending), .strobes(strobes), .badAccess(badAccess)
  );

  ps2c_dp #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .devAvail(devAvail), .devByte(devByte), .pending(pending),
    .rdData(rdData), .devPop(devPop), .txByte(txByte),
    .txValid(txValid), .irq(irq)
  );

  // forcing bit written to control raises irq next cycle
  assert_irq_force_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cs && we && addr < ADDR_W'(4) && wrData[3]) |=> irq);

  // status constant bits
  assert_status_fixed_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cs && !we && addr[ADDR_W-1:2] == (ADDR_W-2)'(1)) |=>
      (rdData[6] && rdData[DATA_W-1:7] == '0 && !rdData[5] && !rdData[3] && rdData[1:0] == 2'b00));

  // interrupt-status bit 1 reads as one
  assert_isr_fixed_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cs && !we && addr[ADDR_W-1:2] == (ADDR_W-2)'(4)) |=> (rdData[1] && rdData[DATA_W-1:2] == '0));
endmodule

// File: tb/sim_ps2c_top.sv
module sim_ps2c_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cs = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        badAccess;
  logic        devAvail = 1'b0;
  logic [7:0]  devByte = '0;
  logic        devPop;
  logic [7:0]  txByte;
  logic        txValid;
  logic        irq;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  ps2c_top u0 (
    .clk(clk), .rstN(rstN), .cs(cs), .we(we), .addr(addr), .wrData(wrData),
    .rdData(rdData), .badAccess(badAccess), .devAvail(devAvail), .devByte(devByte),
    .devPop(devPop), .txByte(txByte), .txValid(txValid), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, sample at the next negedge (after the registering edge)
  task automatic busRead(input logic [11:0] a, output logic [31:0] d, output logic b, output logic p);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    cs = 1'b0;
    d = rdData; b = badAccess; p = devPop;
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] v, output logic b);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = a; wrData = v;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
    b = badAccess;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    check("R1 rdData", rdData, 0);
    check("R1 irq/bad/pop/tx", {28'd0, irq, badAccess, devPop, txValid}, 0);
  endtask

  task automatic testRegs();
    logic [31:0] d; logic b, p;
    busWrite(12'h000, 32'hA5A5_5A42, b);
    busWrite(12'h00C, 32'h1234_5678, b);
    busRead(12'h000, d, b, p);
    check("R2 control readback", d, 32'hA5A5_5A42);
    busRead(12'h00C, d, b, p);
    check("R2 divisor readback", d, 32'h1234_5678);
    busWrite(12'h000, 32'h0, b);
  endtask

  task automatic testReceive();
    logic [31:0] d; logic b, p;
    busRead(12'h004, d, b, p);
    check("R3 status idle", d, 32'h40);
    busRead(12'h010, d, b, p);
    check("R7 isr idle", d, 32'h2);
    devByte = 8'h37;
    // R11: status read issued in the cycle devAvail rises
    @(negedge clk);
    devAvail = 1'b1;
    cs = 1'b1; we = 1'b0; addr = 12'h004;
    @(negedge clk);
    cs = 1'b0;
    check("R11 pending lags devAvail", rdData, 32'h40);
    busRead(12'h004, d, b, p);
    check("R11/R3 status pending, parity of old byte", d, 32'h50);
    busRead(12'h010, d, b, p);
    check("R7 isr pending", d, 32'h3);
    busRead(12'h008, d, b, p);
    check("R4 data read pops", d, 32'h37);
    check("R4 devPop pulse", {31'd0, p}, 1);
    devAvail = 1'b0;
    @(negedge clk);
    check("R4 devPop one cycle", {31'd0, devPop}, 0);
    idle(1);
    busRead(12'h004, d, b, p);
    check("R3 parity of held byte", d, 32'h44);
    busRead(12'h008, d, b, p);
    check("R4 empty read repeats byte", d, 32'h37);
    check("R4 no pop when empty", {31'd0, p}, 0);
  endtask

  task automatic testTransmit();
    logic b;
    busWrite(12'h008, 32'h1234_56C3, b);
    check("R5 txByte", {24'd0, txByte}, 32'hC3);
    check("R5 txValid", {31'd0, txValid}, 1);
    @(negedge clk);
    check("R5 txValid one cycle", {31'd0, txValid}, 0);
  endtask

  task automatic testIrq();
    logic b;
    busWrite(12'h000, 32'h10, b);
    check("R6 gated, nothing pending", {31'd0, irq}, 0);
    @(negedge clk);
    devAvail = 1'b1;
    @(negedge clk);
    check("R6 pending and enable", {31'd0, irq}, 1);
    devAvail = 1'b0;
    @(negedge clk);
    check("R6 falls with pending", {31'd0, irq}, 0);
    busWrite(12'h000, 32'h08, b);
    check("R6 forced", {31'd0, irq}, 1);
    busWrite(12'h000, 32'h00, b);
    check("R6 cleared", {31'd0, irq}, 0);
  endtask

  task automatic testIdent();
    logic [31:0] d; logic b, p;
    logic [7:0] idExp [8] = '{8'h50, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 8; i++) begin
      busRead(12'hFE0 + 12'(i * 4) + 12'(i % 4), d, b, p);
      check("R8 id byte", d, {24'd0, idExp[i]});
      check("R8 id not bad", {31'd0, b}, 0);
    end
  endtask

  task automatic testUnmapped();
    logic [31:0] d; logic b, p;
    busRead(12'h014, d, b, p);
    check("R9 unmapped read data", d, 0);
    check("R9 unmapped read flag", {31'd0, b}, 1);
    busRead(12'hFDC, d, b, p);
    check("R9 below id strip", {d[30:0], b}, 1);
    @(negedge clk);
    check("R9 flag one cycle", {31'd0, badAccess}, 0);
    busWrite(12'h000, 32'h0000_0055, b);
    busWrite(12'h004, 32'hFFFF_FFFF, b);
    check("R10 status write flagged", {31'd0, b}, 1);
    busWrite(12'h010, 32'hFFFF_FFFF, b);
    check("R10 isr write flagged", {31'd0, b}, 1);
    busWrite(12'h020, 32'hFFFF_FFFF, b);
    busWrite(12'hFE0, 32'hFFFF_FFFF, b);
    check("R10 id write flagged", {31'd0, b}, 1);
    check("R10 no irq from ignored writes", {31'd0, irq}, 0);
    busRead(12'h000, d, b, p);
    check("R10 control untouched", d, 32'h55);
    busRead(12'h00C, d, b, p);
    check("R10 divisor untouched", d, 32'h1234_5678);
    busRead(12'hFE0, d, b, p);
    check("R10 id untouched", d, 32'h50);
    busRead(12'h008, d, b, p);
    check("R10 data byte untouched", d, 32'h37);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegs();
    testReceive();
    testTransmit();
    testIrq();
    testIdent();
    testUnmapped();
    idle(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule